// File: doc/BRIEF.md
# Fault-Injectable Register File

This block is a general-purpose register file of 32 words of 32 bits with two combinational read ports and one synchronous write port, extended by a fault-control interface for dependability experiments. An experiment harness supplies every fault parameter: the fault class, a target register, an alternate register index, a 32-bit error pattern and the port the fault is aimed at. It then pulses a strobe on the clock edge that closes a microinstruction. The block creates no randomness of its own.

Two families of transient fault are modelled. Value upsets flip bits of a stored word at the strobe edge. The pattern is either XORed into a named register, or into whichever register was written most recently. Address-decoder faults are armed by the strobe and corrupt exactly one later access on the chosen port. The decoder can select nothing, the wrong register, or an extra register, and reads and writes behave differently in each case. A status output shows while a decoder fault is waiting. When nothing is armed the block behaves as a plain register file.

Top module: `fi_regfile`

## Requirements
- R1: After reset every register reads as zero and `fault_armed` is low.
- R2: With no decoder fault applying, a write with `wr_en` high updates register `wr_sel` at the clock edge, and each read port shows register `rdN_sel` combinationally in the same cycle, whatever its `rdN_en`.
- R3: A strobe with `inj_kind` = 1 (storage upset) XORs `inj_pattern` into register `inj_target` at that edge, on top of any write made to that register at the same edge.
- R4: A strobe with `inj_kind` = 2 (transfer upset) XORs `inj_pattern` into the register actually written by the most recent earlier write (index 0 after reset). A suppressed write does not count; a wrong-decoder write counts as a write to the alternate register.
- R5: A strobe with `inj_kind` 3, 4 or 5 arms a decoder fault that stores kind, port (`inj_port` 0 = read port 0, 1 = read port 1, 2 or 3 = write port) and `inj_alt`, and `fault_armed` is high from the next cycle on. Any strobe with another kind disarms. An armed fault disarms at the edge that ends the first access on its port (`rd0_en`, `rd1_en` or `wr_en` high), unless a strobe comes at that same edge.
- R6: Kind 3 (inactive decoder): the faulted read returns zero, and the faulted write changes no register.
- R7: Kind 4 (wrong decoder): the faulted read returns register `alt` instead of the addressed one, and the faulted write lands in register `alt` only.
- R8: Kind 5 (extra decoder): the faulted read returns the bitwise OR of the addressed and alternate registers when `extra_and` is 0, or their AND when it is 1. The faulted write stores the data in both registers.
- R9: An armed fault leaves the other ports untouched, and accesses on those ports do not disarm it.
- R10: A strobe while a fault is armed replaces the armed fault with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write access |
| wr_sel | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| rd0_en | input | 1 | Read port 0 access marker |
| rd0_sel | input | 5 | Read port 0 index |
| rd0_data | output | 32 | Read port 0 data |
| rd1_en | input | 1 | Read port 1 access marker |
| rd1_sel | input | 5 | Read port 1 index |
| rd1_data | output | 32 | Read port 1 data |
| inj_strobe | input | 1 | Fault injection strobe, microinstruction boundary |
| inj_kind | input | 3 | Fault class code |
| inj_port | input | 2 | Port a decoder fault is aimed at |
| inj_target | input | 5 | Storage-upset target register |
| inj_alt | input | 5 | Alternate register for decoder faults |
| inj_pattern | input | 32 | XOR error pattern |
| extra_and | input | 1 | Extra-decoder read combine: 0 OR, 1 AND |
| fault_armed | output | 1 | A decoder fault is waiting |

## Verification
Read data is combinational, so a faulted or plain read is due in the same cycle as its select and enable. Writes and upsets become visible on the read ports in the first cycle after their edge. `fault_armed` rises in the cycle after an arming strobe and falls in the cycle after the consuming access. The bench changes inputs on the falling edge, compares both read ports and the flag against its model 2 ns later, and advances the model only at the following rising edge. The expected value of every cycle therefore comes from the state built up to the previous edge.

// File: rtl/fi_pkg.sv
package fi_pkg;
   localparam logic [2:0] KIND_NONE   = 3'd0;
   localparam logic [2:0] KIND_STORE  = 3'd1;
   localparam logic [2:0] KIND_XFER   = 3'd2;
   localparam logic [2:0] KIND_OFF    = 3'd3;
   localparam logic [2:0] KIND_WRONG  = 3'd4;
   localparam logic [2:0] KIND_EXTRA  = 3'd5;

   localparam logic [1:0] PORT_RD0 = 2'd0;
   localparam logic [1:0] PORT_RD1 = 2'd1;

   function automatic logic is_decoder_kind(input logic [2:0] k);
      return (k == KIND_OFF) || (k == KIND_WRONG) || (k == KIND_EXTRA);
   endfunction
endpackage

// File: rtl/fi_arm_ctrl.sv
module fi_arm_ctrl
   import fi_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int NUM_RD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [2:0]        kind,
   input  logic [1:0]        port,
   input  logic [ADDR_W-1:0] alt,
   input  logic [NUM_RD-1:0] rd_access,
   input  logic              wr_access,
   output logic              armed,
   output logic [2:0]        arm_kind,
   output logic [1:0]        arm_port,
   output logic [ADDR_W-1:0] arm_alt,
   output logic [NUM_RD-1:0] hit_rd,
   output logic              hit_wr
);
   logic consumed;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_hit
      assign hit_rd[p] = armed && (arm_port == 2'(p));
   end
   assign hit_wr   = armed && arm_port[1];
   assign consumed = |(hit_rd & rd_access) || (hit_wr && wr_access);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         arm_kind <= KIND_NONE;
         arm_port <= PORT_RD0;
         arm_alt  <= '0;
      end else if (strobe) begin
         armed    <= is_decoder_kind(kind);
         arm_kind <= kind;
         arm_port <= port;
         arm_alt  <= alt;
      end else if (consumed) begin
         armed    <= 1'b0;
      end
   end
endmodule

// File: rtl/fi_read_port.sv
module fi_read_port
   import fi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   localparam int NREGS = 1 << ADDR_W
) (
   input  logic [NREGS-1:0][DATA_W-1:0] regs,
   input  logic [ADDR_W-1:0]            sel,
   input  logic                         en,
   input  logic                         hit,
   input  logic [2:0]                   kind,
   input  logic [ADDR_W-1:0]            alt,
   input  logic                         comb_and,
   output logic [DATA_W-1:0]            data
);
   logic [DATA_W-1:0] addressed, other;

   assign addressed = regs[sel];
   assign other     = regs[alt];

   always_comb begin
      data = addressed;
      if (hit && en) begin
         case (kind)
            KIND_OFF:   data = '0;
            KIND_WRONG: data = other;
            KIND_EXTRA: data = comb_and ? (addressed & other) : (addressed | other);
            default:    data = addressed;
         endcase
      end
   end
endmodule

// File: rtl/fi_regfile.sv
module fi_regfile
   import fi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd0_en,
   input  logic [ADDR_W-1:0] rd0_sel,
   output logic [DATA_W-1:0] rd0_data,
   input  logic              rd1_en,
   input  logic [ADDR_W-1:0] rd1_sel,
   output logic [DATA_W-1:0] rd1_data,
   input  logic              inj_strobe,
   input  logic [2:0]        inj_kind,
   input  logic [1:0]        inj_port,
   input  logic [ADDR_W-1:0] inj_target,
   input  logic [ADDR_W-1:0] inj_alt,
   input  logic [DATA_W-1:0] inj_pattern,
   input  logic              extra_and,
   output logic              fault_armed
);
   localparam int NREGS  = 1 << ADDR_W;
   localparam int NUM_RD = 2;

   initial begin
      assert (DATA_W >= 1);
      assert (ADDR_W >= 1 && ADDR_W <= 8);
   end

   logic [NREGS-1:0][DATA_W-1:0]  regs_q, regs_d;
   logic [ADDR_W-1:0]             last_q, last_d;
   logic [2:0]                    arm_kind_q;
   logic [1:0]                    arm_port_q;
   logic [ADDR_W-1:0]             arm_alt_q;
   logic [NUM_RD-1:0]             hit_rd;
   logic                          hit_wr;
   logic [NUM_RD-1:0]             rd_en_v;
   logic [NUM_RD-1:0][ADDR_W-1:0] rd_sel_v;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data_v;

   assign rd_en_v  = {rd1_en, rd0_en};
   assign rd_sel_v = {rd1_sel, rd0_sel};
   assign rd0_data = rd_data_v[0];
   assign rd1_data = rd_data_v[1];

   fi_arm_ctrl #(.ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) i_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (inj_strobe),
      .kind      (inj_kind),
      .port      (inj_port),
      .alt       (inj_alt),
      .rd_access (rd_en_v),
      .wr_access (wr_en),
      .armed     (fault_armed),
      .arm_kind  (arm_kind_q),
      .arm_port  (arm_port_q),
      .arm_alt   (arm_alt_q),
      .hit_rd    (hit_rd),
      .hit_wr    (hit_wr)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      fi_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_port (
         .regs     (regs_q),
         .sel      (rd_sel_v[p]),
         .en       (rd_en_v[p]),
         .hit      (hit_rd[p]),
         .kind     (arm_kind_q),
         .alt      (arm_alt_q),
         .comb_and (extra_and),
         .data     (rd_data_v[p])
      );
   end

   always_comb begin
      regs_d = regs_q;
      last_d = last_q;
      if (wr_en) begin
         if (hit_wr) begin
            case (arm_kind_q)
               KIND_OFF: ;
               KIND_WRONG: begin
                  regs_d[arm_alt_q] = wr_data;
                  last_d            = arm_alt_q;
               end
               KIND_EXTRA: begin
                  regs_d[wr_sel]    = wr_data;
                  regs_d[arm_alt_q] = wr_data;
                  last_d            = wr_sel;
               end
               default: begin
                  regs_d[wr_sel] = wr_data;
                  last_d         = wr_sel;
               end
            endcase
         end else begin
            regs_d[wr_sel] = wr_data;
            last_d         = wr_sel;
         end
      end
      if (inj_strobe && inj_kind == KIND_STORE)
         regs_d[inj_target] = regs_d[inj_target] ^ inj_pattern;
      else if (inj_strobe && inj_kind == KIND_XFER)
         regs_d[last_q] = regs_d[last_q] ^ inj_pattern;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
         last_q <= '0;
      end else begin
         regs_q <= regs_d;
         last_q <= last_d;
      end
   end
endmodule

// File: rtl/fi_regfile_chk.sv
module fi_regfile_chk
   import fi_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inj_strobe,
   input logic [2:0]        inj_kind,
   input logic              rd0_en,
   input logic              rd1_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd0_data,
   input logic [DATA_W-1:0] rd1_data,
   input logic              fault_armed,
   input logic [2:0]        arm_kind,
   input logic [1:0]        arm_port
);
   logic on_port;
   assign on_port = (arm_port == PORT_RD0 && rd0_en) ||
                    (arm_port == PORT_RD1 && rd1_en) ||
                    (arm_port[1] && wr_en);

   p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !fault_armed);

   p_arm_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_strobe && inj_kind >= KIND_OFF && inj_kind <= KIND_EXTRA) |=> fault_armed);

   p_disarm_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_strobe && !(inj_kind >= KIND_OFF && inj_kind <= KIND_EXTRA)) |=> !fault_armed);

   p_single_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_strobe && fault_armed && on_port) |=> !fault_armed);

   p_other_port_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_strobe && fault_armed && !on_port) |=> fault_armed);

   p_off_read0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_armed && arm_kind == KIND_OFF && arm_port == PORT_RD0 && rd0_en) |-> rd0_data == '0);

   p_off_read1_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_armed && arm_kind == KIND_OFF && arm_port == PORT_RD1 && rd1_en) |-> rd1_data == '0);
endmodule

bind fi_regfile fi_regfile_chk #(.DATA_W(DATA_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .inj_strobe  (inj_strobe),
   .inj_kind    (inj_kind),
   .rd0_en      (rd0_en),
   .rd1_en      (rd1_en),
   .wr_en       (wr_en),
   .rd0_data    (rd0_data),
   .rd1_data    (rd1_data),
   .fault_armed (fault_armed),
   .arm_kind    (arm_kind_q),
   .arm_port    (arm_port_q)
);

// File: tb/test_fi_regfile.sv
module test_fi_regfile;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd0_en, rd1_en, inj_strobe, extra_and;
   logic [4:0]  wr_sel, rd0_sel, rd1_sel, inj_target, inj_alt;
   logic [31:0] wr_data, inj_pattern;
   logic [2:0]  inj_kind;
   logic [1:0]  inj_port;
   logic [31:0] rd0_data, rd1_data;
   logic        fault_armed;

   always #10 clk = ~clk;

   fi_regfile i_fi_regfile (.*);

   int    errors = 0;
   int    checks = 0;
   string cur_tag = "R2";

   logic [31:0] m_regs [32];
   bit          m_armed;
   int          m_kind, m_port, m_alt, m_last;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit aimed(int p);
      if (p == 2) return m_armed && m_port >= 2;
      return m_armed && m_port == p;
   endfunction

   function automatic logic [31:0] exp_rd(int p, int sel, bit en);
      if (aimed(p) && en) begin
         case (m_kind)
            3: return 32'h0;
            4: return m_regs[m_alt];
            5: return extra_and ? (m_regs[sel] & m_regs[m_alt]) : (m_regs[sel] | m_regs[m_alt]);
            default: return m_regs[sel];
         endcase
      end
      return m_regs[sel];
   endfunction

   function automatic string rd_tag(int p, bit en);
      if (aimed(p) && en) begin
         case (m_kind)
            3: return "R6";
            4: return "R7";
            default: return "R8";
         endcase
      end
      return (m_armed) ? "R9" : cur_tag;
   endfunction

   task automatic model_reset();
      foreach (m_regs[i]) m_regs[i] = 32'h0;
      m_armed = 0; m_kind = 0; m_port = 0; m_alt = 0; m_last = 0;
   endtask

   task automatic model_edge();
      logic [31:0] n [32];
      int          nl;
      bit          used;
      n  = m_regs;
      nl = m_last;
      used = (aimed(0) && rd0_en) || (aimed(1) && rd1_en) || (aimed(2) && wr_en);
      if (wr_en) begin
         if (aimed(2) && m_kind == 3) begin
         end else if (aimed(2) && m_kind == 4) begin
            n[m_alt] = wr_data; nl = m_alt;
         end else if (aimed(2) && m_kind == 5) begin
            n[wr_sel] = wr_data; n[m_alt] = wr_data; nl = int'(wr_sel);
         end else begin
            n[wr_sel] = wr_data; nl = int'(wr_sel);
         end
      end
      if (inj_strobe && inj_kind == 3'd1) n[inj_target] ^= inj_pattern;
      if (inj_strobe && inj_kind == 3'd2) n[m_last] ^= inj_pattern;
      if (inj_strobe) begin
         m_armed = (inj_kind >= 3'd3 && inj_kind <= 3'd5);
         m_kind = int'(inj_kind); m_port = int'(inj_port); m_alt = int'(inj_alt);
      end else if (used) begin
         m_armed = 0;
      end
      m_regs = n;
      m_last = nl;
   endtask

   task automatic quiet();
      wr_en = 0; rd0_en = 0; rd1_en = 0; inj_strobe = 0;
   endtask

   // inputs are set after a falling edge; compare 2 ns later, then advance the model at the rising edge
   task automatic step();
      #2;
      chk(rd_tag(0, rd0_en), rd0_data, exp_rd(0, int'(rd0_sel), rd0_en));
      chk(rd_tag(1, rd1_en), rd1_data, exp_rd(1, int'(rd1_sel), rd1_en));
      chk("R5", {31'h0, fault_armed}, {31'h0, m_armed});
      @(posedge clk);
      model_edge();
      @(negedge clk);
      quiet();
   endtask

   task automatic write(int sel, logic [31:0] d);
      wr_en = 1; wr_sel = 5'(sel); wr_data = d; step();
   endtask

   task automatic read(int a, int b, bit e0, bit e1);
      rd0_sel = 5'(a); rd1_sel = 5'(b); rd0_en = e0; rd1_en = e1; step();
   endtask

   task automatic strobe(int kind, int port, int tgt, int alt, logic [31:0] pat);
      inj_strobe = 1; inj_kind = 3'(kind); inj_port = 2'(port);
      inj_target = 5'(tgt); inj_alt = 5'(alt); inj_pattern = pat; step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      quiet();
      wr_sel = 0; wr_data = 0; rd0_sel = 0; rd1_sel = 0; inj_kind = 0; inj_port = 0;
      inj_target = 0; inj_alt = 0; inj_pattern = 0; extra_and = 0;
      rst_n = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: all registers zero after reset
      cur_tag = "R1";
      for (int i = 0; i < 16; i++) read(i, i + 16, 1'b0, 1'b0);
      // R2: plain writes and reads on both ports
      cur_tag = "R2";
      for (int i = 1; i < 16; i++) write(i, 32'h1111_0000 + 32'(i * 32'h0101));
      for (int i = 0; i < 16; i++) read(i, 15 - i, 1'b1, 1'b1);
      // R3: storage upset, and on top of a same-edge write
      cur_tag = "R3";
      strobe(1, 0, 3, 0, 32'h0000_00F0);
      read(3, 3, 1'b0, 1'b1);
      wr_en = 1; wr_sel = 5; wr_data = 32'hAAAA_5555; strobe(1, 0, 5, 0, 32'hFFFF_0000);
      read(5, 3, 1'b1, 1'b0);
      // R4: transfer upset hits last written register
      cur_tag = "R4";
      write(7, 32'h1234_5678);
      strobe(2, 0, 0, 0, 32'h8000_0001);
      read(7, 6, 1'b0, 1'b0);
      // R6: inactive decoder, read port 0 then write port
      cur_tag = "R9";
      strobe(3, 0, 0, 0, 0);
      read(2, 2, 1'b1, 1'b1);
      read(2, 2, 1'b1, 1'b0);
      strobe(3, 2, 0, 0, 0);
      write(4, 32'hDEAD_BEEF);
      read(4, 4, 1'b0, 1'b0);
      // R7: wrong decoder on read port 1 and on write port
      strobe(4, 1, 0, 6, 0);
      read(2, 2, 1'b1, 1'b1);
      strobe(4, 3, 0, 9, 0);
      write(10, 32'hC0FF_EE00);
      read(9, 10, 1'b0, 1'b0);
      cur_tag = "R4";
      strobe(2, 0, 0, 0, 32'h0000_FFFF);
      read(9, 10, 1'b0, 1'b0);
      // R8: extra decoder OR, AND and double write
      cur_tag = "R9";
      strobe(5, 0, 0, 1, 0);
      extra_and = 0; read(2, 2, 1'b1, 1'b0);
      strobe(5, 1, 0, 1, 0);
      extra_and = 1; read(2, 2, 1'b0, 1'b1);
      extra_and = 0;
      strobe(5, 2, 0, 12, 0);
      write(11, 32'h0F0F_0F0F);
      read(11, 12, 1'b0, 1'b0);
      // R9: accesses on other ports keep the fault armed
      strobe(3, 1, 0, 0, 0);
      read(1, 1, 1'b1, 1'b0);
      write(13, 32'h5A5A_5A5A);
      read(13, 13, 1'b1, 1'b0);
      read(13, 13, 1'b0, 1'b1);
      // R10: re-arm replaces pending fault; kind 0 disarms
      cur_tag = "R10";
      strobe(3, 0, 0, 0, 0);
      strobe(4, 0, 0, 3, 0);
      read(8, 8, 1'b1, 1'b1);
      strobe(5, 0, 0, 4, 0);
      strobe(0, 0, 0, 0, 0);
      read(8, 8, 1'b1, 1'b1);
      // mixed traffic against the model
      cur_tag = "R2";
      for (int c = 0; c < 400; c++) begin
         wr_en = ($urandom_range(0, 2) == 0); wr_sel = 5'($urandom); wr_data = $urandom;
         rd0_en = $urandom_range(0, 1) == 1; rd0_sel = 5'($urandom);
         rd1_en = $urandom_range(0, 1) == 1; rd1_sel = 5'($urandom);
         extra_and = $urandom_range(0, 1) == 1;
         inj_strobe = ($urandom_range(0, 5) == 0); inj_kind = 3'($urandom_range(0, 6));
         inj_port = 2'($urandom); inj_target = 5'($urandom); inj_alt = 5'($urandom);
         inj_pattern = $urandom;
         step();
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule